// File: doc/BRIEF.md
# Word-Level Spare-Bit Repair Controller

This block sits between a host and a small word-organised memory and hides hard (stuck-at) cell faults from the host. Every host write is stored and then read back at once to check it. When the read-back disagrees with the written data at a bit column that no pointer covers yet, the controller records that column in a pointer owned by the word's memory block. It then rewrites the word so that the spare bit paired with that pointer holds the correct value. Host reads return the stored user bits, with the spare value put in place of every pointed column whose spare is enabled in that word.

Pointers are shared by all words of a block, but every spare bit in every word has its own enable bit. A spare is filled and enabled whenever its word is written after the pointer was allocated. A spare that fails its own check is retired: its pointer is copied to the next free pointer and the spare is flagged as corrupt. The behavioural memory array is part of the block. It has a test port that forces chosen cells of one address to fixed values on read, so that faults can be injected.

Top module: `spare_repair_ctrl`

## Requirements
- R1: After reset `ready` is 1, `rvalid` and `err` are 0, every pointer is inactive and the whole array reads as zero.
- R2: A host request is taken when `req` and `ready` are both high. A write that verifies clean keeps `ready` low for exactly 2 cycles (write, then verify). A read raises `rvalid` for one cycle, on the second clock edge after acceptance, with the read data on `rdata`.
- R3: When verify finds a mismatch in a user column that no active pointer of the block covers, that column goes into the lowest-indexed inactive pointer, which becomes active. The word is then rewritten and verified again, so one repair step makes `ready` stay low for 4 cycles. A later read returns the written data.
- R4: When several new faulty columns show up in one word, they are repaired one per step, lowest column first. Two new faults in a word with two free pointers keep `ready` low for 6 cycles, and both columns read back correctly.
- R5: When a new faulty column is found and the block has no inactive pointer, `err` goes high when the write completes, the write takes 2 cycles, and reads return the raw faulty bit. `err` clears when the next write is accepted.
- R6: Any write to any word of a block fills and enables that word's spare for every active pointer of the block. A fault that appears in that word afterwards, at a pointed column, is hidden on read.
- R7: In a word whose spare enable is clear (the word was last written before the pointer was activated), the raw bit at the pointed column is returned.
- R8: Pointers belong to one block. The block number is the address divided by the number of words per block (address bits [3:2] with the default sizes). A pointer in one block never changes reads or repairs in another block.
- R9: Physical word layout: user bits at [USER_W-1:0]; spare i has its value at bit USER_W+2i and its enable at USER_W+2i+1. If the value or enable of an active, non-corrupt spare fails verify, its pointer is copied into the lowest inactive pointer and the spare is marked corrupt. The word is rewritten (4 busy cycles in total), and corrupt spares are ignored by later verifies.
- R10: On read, when several enabled spares point at the same column, the spare with the higher index wins.
- R11: Fault injection: whenever the array is read at address `flt_addr`, each bit set in `flt_mask` returns the matching bit of `flt_val` in place of the stored bit. Writes are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address (block number in upper bits) |
| wdata | input | USER_W | Write data |
| flt_addr | input | ADDR_W | Address whose cells are forced on read |
| flt_mask | input | PHYS_W | Physical bits forced at `flt_addr` |
| flt_val | input | PHYS_W | Values of the forced bits |
| ready | output | 1 | Controller idle, can take a request |
| rdata | output | USER_W | Corrected read data |
| rvalid | output | 1 | One-cycle read data strobe |
| err | output | 1 | Last write met a fault that could not be repaired |

## Verification
Directed stimulus places stuck cells at chosen columns in words of different blocks. The busy length of each write then tells a clean write (2), one repair step (4) and two steps (6) apart. Read-back then shows whether a value comes from a spare or from the raw cell. A fault injected after a later write to a sibling word separates lazy spare filling from a missing enable. The same column faulted in a second block shows that pointers stay local to their block. Forcing a spare value bit wrong while a higher spare covers the same column shows both retirement and read precedence. A fixed-seed random mix of reads and writes with no faults then checks plain storage against a bench model after all these repairs have left active pointers behind.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WR   = 2'd1,
        S_VF   = 2'd2,
        S_RD   = 2'd3
    } srp_state_e;
endpackage

// File: rtl/srp_ram.sv
module srp_ram #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [DATA_W-1:0] flt_mask,
    input  logic [DATA_W-1:0] flt_val,
    output logic [DATA_W-1:0] rdata
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic [DATA_W-1:0]            raw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    // stuck cells only show on the read side
    always_comb begin
        raw   = mem_q[addr];
        rdata = (addr == flt_addr) ? ((raw & ~flt_mask) | (flt_val & flt_mask)) : raw;
    end
endmodule

// File: rtl/srp_encode.sv
module srp_encode #(
    parameter int USER_W = 8,
    parameter int SPARES = 2,
    parameter int PTR_W  = 3
) (
    input  logic [USER_W-1:0]             data,
    input  logic [SPARES-1:0][PTR_W-1:0]  ptr,
    input  logic [SPARES-1:0]             act,
    output logic [USER_W+2*SPARES-1:0]    phys
);
    assign phys[USER_W-1:0] = data;

    for (genvar i = 0; i < SPARES; i++) begin : g_sp
        // value bit then enable bit for each spare
        assign phys[USER_W+2*i]   = act[i] & data[ptr[i]];
        assign phys[USER_W+2*i+1] = act[i];
    end
endmodule

// File: rtl/srp_merge.sv
module srp_merge #(
    parameter int USER_W = 8,
    parameter int SPARES = 2,
    parameter int PTR_W  = 3
) (
    input  logic [USER_W+2*SPARES-1:0]    raw,
    input  logic [SPARES-1:0][PTR_W-1:0]  ptr,
    input  logic [SPARES-1:0]             act,
    output logic [USER_W-1:0]             data
);
    always_comb begin
        data = raw[USER_W-1:0];
        // ascending order: a later (higher) spare overrides an earlier one
        for (int i = 0; i < SPARES; i++) begin
            if (act[i] && raw[USER_W+2*i+1]) begin
                data[ptr[i]] = raw[USER_W+2*i];
            end
        end
    end
endmodule

// File: rtl/spare_repair_ctrl.sv
module spare_repair_ctrl
    import srp_pkg::*;
#(
    parameter int USER_W    = 8,
    parameter int SPARES    = 2,
    parameter int BLK_WORDS = 4,
    parameter int NUM_BLKS  = 4,
    localparam int PTR_W    = $clog2(USER_W),
    localparam int PHYS_W   = USER_W + 2*SPARES,
    localparam int DEPTH    = BLK_WORDS * NUM_BLKS,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [USER_W-1:0] wdata,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [PHYS_W-1:0] flt_mask,
    input  logic [PHYS_W-1:0] flt_val,
    output logic              ready,
    output logic [USER_W-1:0] rdata,
    output logic              rvalid,
    output logic              err
);
    localparam int BLK_SH = $clog2(BLK_WORDS);
    localparam int BLK_W  = ADDR_W - BLK_SH;
    localparam int SP_W   = (SPARES > 1) ? $clog2(SPARES) : 1;

    typedef struct packed {
        srp_state_e                                st;
        logic [ADDR_W-1:0]                         addr;
        logic [USER_W-1:0]                         data;
        logic [USER_W-1:0]                         rdata;
        logic                                      rvalid;
        logic                                      err;
        logic [NUM_BLKS-1:0][SPARES-1:0][PTR_W-1:0] ptr;
        logic [NUM_BLKS-1:0][SPARES-1:0]           act;
        logic [NUM_BLKS-1:0][SPARES-1:0]           csp;
    } ctl_t;

    ctl_t d, q;

    logic [BLK_W-1:0]              blk;
    logic [SPARES-1:0][PTR_W-1:0]  cur_ptr;
    logic [SPARES-1:0]             cur_act;
    logic [SPARES-1:0]             cur_csp;
    logic [PHYS_W-1:0]             wphys, mem_rdata, mismatch;
    logic [USER_W-1:0]             merged, covered, new_user;
    logic [SPARES-1:0]             spare_bad;
    logic [PTR_W-1:0]              new_pos;
    logic [SP_W-1:0]               free_idx, bad_idx;
    logic                          have_free, mem_we;

    assign blk     = q.addr[ADDR_W-1:BLK_SH];
    assign cur_ptr = q.ptr[blk];
    assign cur_act = q.act[blk];
    assign cur_csp = q.csp[blk];

    srp_encode #(.USER_W(USER_W), .SPARES(SPARES), .PTR_W(PTR_W)) u_enc (
        .data(q.data), .ptr(cur_ptr), .act(cur_act), .phys(wphys)
    );

    srp_ram #(.DATA_W(PHYS_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(q.addr), .wdata(wphys),
        .flt_addr(flt_addr), .flt_mask(flt_mask), .flt_val(flt_val), .rdata(mem_rdata)
    );

    srp_merge #(.USER_W(USER_W), .SPARES(SPARES), .PTR_W(PTR_W)) u_mrg (
        .raw(mem_rdata), .ptr(cur_ptr), .act(cur_act), .data(merged)
    );

    // verify analysis of the read-back word
    always_comb begin
        mismatch  = mem_rdata ^ wphys;
        covered   = '0;
        spare_bad = '0;
        new_pos   = '0;
        free_idx  = '0;
        bad_idx   = '0;
        for (int i = 0; i < SPARES; i++) begin
            for (int p = 0; p < USER_W; p++) begin
                if (cur_act[i] && cur_ptr[i] == PTR_W'(p)) covered[p] = 1'b1;
            end
            spare_bad[i] = cur_act[i] & ~cur_csp[i]
                         & (mismatch[USER_W+2*i] | mismatch[USER_W+2*i+1]);
        end
        new_user  = mismatch[USER_W-1:0] & ~covered;
        have_free = ~&cur_act;
        for (int k = USER_W-1; k >= 0; k--) begin
            if (new_user[k]) new_pos = PTR_W'(k);
        end
        for (int i = SPARES-1; i >= 0; i--) begin
            if (!cur_act[i]) free_idx = SP_W'(i);
            if (spare_bad[i]) bad_idx = SP_W'(i);
        end
    end

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        mem_we   = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req) begin
                    d.addr = addr;
                    d.data = wdata;
                    if (we) begin
                        d.st  = S_WR;
                        d.err = 1'b0;
                    end else begin
                        d.st = S_RD;
                    end
                end
            end
            S_WR: begin
                mem_we = 1'b1;
                d.st   = S_VF;
            end
            S_RD: begin
                d.rdata  = merged;
                d.rvalid = 1'b1;
                d.st     = S_IDLE;
            end
            S_VF: begin
                d.st = S_IDLE;
                if (|new_user) begin
                    if (have_free) begin
                        d.ptr[blk][free_idx] = new_pos;
                        d.act[blk][free_idx] = 1'b1;
                        d.st                 = S_WR;
                    end else begin
                        d.err = 1'b1;
                    end
                end else if (|spare_bad) begin
                    d.csp[blk][bad_idx] = 1'b1;
                    if (have_free) begin
                        d.ptr[blk][free_idx] = cur_ptr[bad_idx];
                        d.act[blk][free_idx] = 1'b1;
                        d.st                 = S_WR;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready  = (q.st == S_IDLE);
    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;
    assign err    = q.err;

    // an accepted request always makes the block busy on the next cycle
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);
    p_read_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !we) |-> ##2 rvalid);
    p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && we) |=> !err);

    for (genvar b = 0; b < NUM_BLKS; b++) begin : g_ab
        for (genvar i = 0; i < SPARES; i++) begin : g_ai
            p_act_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
                q.act[b][i] |=> q.act[b][i]);
            p_csp_needs_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
                q.csp[b][i] |-> q.act[b][i]);
            if (i > 0) begin : g_ord
                p_lowest_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    q.act[b][i] |-> q.act[b][i-1]);
            end
        end
    end
endmodule

// File: tb/spare_repair_ctrl_bench.sv
module spare_repair_ctrl_bench;
    localparam int U  = 8;
    localparam int T  = 2;
    localparam int PW = U + 2*T;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n, req, we;
    logic [AW-1:0] addr, flt_addr;
    logic [U-1:0]  wdata, rdata;
    logic [PW-1:0] flt_mask, flt_val;
    logic          ready, rvalid, err;

    always #5 clk = ~clk;

    spare_repair_ctrl u_spare_repair_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .flt_addr(flt_addr), .flt_mask(flt_mask), .flt_val(flt_val),
        .ready(ready), .rdata(rdata), .rvalid(rvalid), .err(err)
    );

    int           nchk = 0;
    int           nfail = 0;
    logic [U-1:0] model [16];

    function automatic logic [U-1:0] forced(input logic [U-1:0] v, input logic [U-1:0] m,
                                            input logic [U-1:0] s);
        return (v & ~m) | (s & m);
    endfunction

    task automatic chk(input bit ok, input string tag, input int actv, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
        end
    endtask

    task automatic set_flt(input logic [AW-1:0] a, input logic [PW-1:0] m, input logic [PW-1:0] v);
        flt_addr = a; flt_mask = m; flt_val = v;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [U-1:0] dat, output int busy);
        req = 1'b1; we = 1'b1; addr = a; wdata = dat;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0; busy = 0;
        while (!ready && busy < 50) begin
            @(posedge clk); #1;
            busy++;
        end
        model[a] = dat;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [U-1:0] dat, output bit v);
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk); #1;
        req = 1'b0;
        @(posedge clk); #1;
        v = rvalid; dat = rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int           b;
        logic [U-1:0] d;
        bit           v;
        void'($urandom(32'd2024));
        for (int k = 0; k < 16; k++) model[k] = '0;
        rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        set_flt('0, '0, '0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(rvalid == 1'b0, "R1 rvalid after reset", rvalid, 0);
        chk(err == 1'b0, "R1 err after reset", err, 0);
        rd(4'd7, d, v);
        chk(v && d == 8'h00, "R1 array cleared", d, 0);

        // R2 clean write and read
        wr(4'd1, 8'hA5, b);
        chk(b == 2, "R2 clean write busy", b, 2);
        rd(4'd1, d, v);
        chk(v == 1'b1, "R2 rvalid timing", v, 1);
        chk(d == 8'hA5, "R2 read data", d, 8'hA5);
        wr(4'd2, 8'h07, b);   // written before any pointer exists in block 0

        // R3 / R11 one stuck column in block 0
        set_flt(4'd0, 12'h008, 12'h000);
        wr(4'd0, 8'hFF, b);
        chk(b == 4, "R3 single repair busy", b, 4);
        rd(4'd0, d, v);
        chk(d == 8'hFF, "R3 repaired read", d, 8'hFF);
        chk(err == 1'b0, "R3 no err", err, 0);

        // R6 lazy fill in a sibling word
        set_flt('0, '0, '0);
        wr(4'd1, 8'h08, b);
        chk(b == 2, "R6 write with active pointer busy", b, 2);
        set_flt(4'd1, 12'h008, 12'h000);
        rd(4'd1, d, v);
        chk(d == 8'h08, "R6 late fault hidden", d, 8'h08);

        // R7 enable clear in a word not rewritten
        set_flt(4'd2, 12'h008, 12'h008);
        rd(4'd2, d, v);
        chk(d == forced(8'h07, 8'h08, 8'h08), "R7 raw bit passes", d, forced(8'h07, 8'h08, 8'h08));

        // R8 block 1 has its own pointers
        set_flt('0, '0, '0);
        wr(4'd5, 8'h08, b);
        set_flt(4'd5, 12'h008, 12'h000);
        rd(4'd5, d, v);
        chk(d == 8'h00, "R8 other block unaffected", d, 8'h00);
        set_flt(4'd4, 12'h008, 12'h000);
        wr(4'd4, 8'hFF, b);
        chk(b == 4, "R8 block 1 allocates own pointer", b, 4);
        rd(4'd4, d, v);
        chk(d == 8'hFF, "R8 block 1 repaired read", d, 8'hFF);

        // R4 two stuck columns in one word of block 2
        set_flt(4'd8, 12'h042, 12'h000);
        wr(4'd8, 8'hFF, b);
        chk(b == 6, "R4 two repair steps busy", b, 6);
        rd(4'd8, d, v);
        chk(d == 8'hFF, "R4 both columns repaired", d, 8'hFF);

        // R5 no free pointer left in block 2
        set_flt(4'd9, 12'h001, 12'h000);
        wr(4'd9, 8'hFF, b);
        chk(b == 2, "R5 unrepairable busy", b, 2);
        chk(err == 1'b1, "R5 err raised", err, 1);
        rd(4'd9, d, v);
        chk(d == forced(8'hFF, 8'h01, 8'h00), "R5 raw faulty bit", d, forced(8'hFF, 8'h01, 8'h00));
        set_flt('0, '0, '0);
        wr(4'd9, 8'h11, b);
        chk(err == 1'b0, "R5 err cleared by next write", err, 0);

        // R9 / R10 spare 0 value bit (bit 8) fails in block 3
        set_flt(4'd12, 12'h020, 12'h000);
        wr(4'd12, 8'hFF, b);
        chk(b == 4, "R9 initial repair busy", b, 4);
        set_flt(4'd12, 12'h120, 12'h000);
        wr(4'd12, 8'hFF, b);
        chk(b == 4, "R9 spare retire busy", b, 4);
        chk(err == 1'b0, "R9 retire without err", err, 0);
        rd(4'd12, d, v);
        chk(d == 8'hFF, "R10 higher spare wins", d, 8'hFF);
        wr(4'd12, 8'hDF, b);
        chk(b == 2, "R9 corrupt spare ignored by verify", b, 2);

        // random traffic without faults
        set_flt('0, '0, '0);
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % 16);
            if ($urandom % 2 == 1) begin
                d = U'($urandom);
                wr(a, d, b);
                chk(b == 2, "R2 random write busy", b, 2);
            end else begin
                rd(a, d, v);
                chk(v && d == model[a], "R2 random read", d, model[a]);
            end
        end
        finish_run();
    end
endmodule